// File: doc/BRIEF.md
# Slave Serial CODEC Port with Mid-Frame Control Exchange

This block is a slave-only synchronous serial port for a CODEC link. The external CODEC supplies the bit clock and every frame-sync pulse. A frame is `FRAME_LEN` bit clocks long. The first slot after the normal sync carries one audio word in each direction, `SLOT_W` bits wide and sent most significant bit first. Outgoing bits change on the falling edge of the bit clock. Incoming bits are taken on the rising edge. The bit clock, sync and receive data are first brought into the system clock domain through a synchronizer, then edge-detected. The system clock must run at least four times faster than the bit clock.

Control words travel in-band. When no control exchange is pending, the port clears bit 0 of each outgoing audio word. When the host writes a control word, the port sets bit 0 of the next outgoing audio word, which tells the CODEC an exchange is wanted. The CODEC answers with a second sync pulse at mid-frame. In the slot after that pulse, the port shifts out the stored control word and captures the incoming control word. Completing that slot clears the pending request.

A sync pulse that arrives at any other position, or at mid-frame when nothing is pending, is taken as a normal frame start. It realigns the port, and a new audio slot begins.

Top module: `sio_codec_slave`

## Requirements
- R1: After reset, `txd_out`, `ctl_pending`, `rx_audio_vld` and `rx_ctl_vld` are 0, and `rx_audio` and `rx_ctl` are all zeros.
- R2: After a normal sync, the port sends the audio word held on `tx_audio`. The word goes out MSB first, on the next `SLOT_W` falling edges of the bit clock. When no request is pending, bit 0 is sent as 0.
- R3: A `ctl_wr` pulse stores `ctl_wdata` and raises `ctl_pending` on the next system clock. While `ctl_pending` is high at a normal sync, bit 0 of that frame's audio word is sent as 1.
- R4: A sync sampled exactly `FRAME_LEN/2` rising edges after the normal sync, while `ctl_pending` is high, starts a control slot. In that slot the most recently written control word is sent MSB first.
- R5: At the end of the control slot, the `SLOT_W` bits received on the following rising edges appear on `rx_ctl`. At the same moment `rx_ctl_vld` pulses for one system clock and `ctl_pending` falls, unless `ctl_wr` fired in the previous cycle.
- R6: After a normal sync, the `SLOT_W` bits sampled on the next rising edges appear MSB first on `rx_audio`. `rx_audio_vld` pulses for one system clock.
- R7: A mid-frame sync with no request pending is a normal sync. It starts a new audio slot and leaves `rx_ctl` unchanged.
- R8: A sync at any position other than frame start and mid-frame restarts the bit position. A new audio slot begins right after it.
- R9: Outside its active slots, `txd_out` is 0, and it changes only on a detected falling edge of the bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Bit clock from the CODEC (asynchronous) |
| fs_in | input | 1 | Frame-sync pulses from the CODEC (asynchronous) |
| rxd_in | input | 1 | Serial data from the CODEC |
| txd_out | output | 1 | Serial data to the CODEC |
| tx_audio | input | SLOT_W | Audio word to send; bit 0 is replaced by the request flag |
| ctl_wr | input | 1 | One-clock write strobe for a control word |
| ctl_wdata | input | SLOT_W | Control word to send |
| ctl_pending | output | 1 | Control exchange requested but not yet completed |
| rx_audio | output | SLOT_W | Last received audio word |
| rx_audio_vld | output | 1 | One-clock strobe when `rx_audio` updates |
| rx_ctl | output | SLOT_W | Last received control word |
| rx_ctl_vld | output | 1 | One-clock strobe when `rx_ctl` updates |

## Verification
The assertions check three things on every cycle:
- both valid strobes last one system clock;
- `txd_out` moves only on a detected falling bit-clock edge;
- a write always raises the pending flag, a control capture always follows a pending request, and that capture clears the flag.

Only the bench scenarios can show the serial content and its position: the forced bit 0, MSB-first order, the mid-frame control slot and the realignment on a stray sync. They do this by running whole frames and comparing every shifted bit.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic {SLOT_AUDIO = 1'b0, SLOT_CTRL = 1'b1} slot_kind_e;
endpackage

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic fs_in,
  input  logic rxd_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic fs_s,
  output logic rxd_s
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sck_q, fs_q, rxd_q;
  logic         sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '1;
      fs_q  <= '0;
      rxd_q <= '0;
      sck_d <= 1'b1;
    end else begin
      sck_q <= {sck_q[TOP-1:0], sck_in};
      fs_q  <= {fs_q[TOP-1:0], fs_in};
      rxd_q <= {rxd_q[TOP-1:0], rxd_in};
      sck_d <= sck_q[TOP];
    end
  end

  assign sck_rise = sck_q[TOP] & ~sck_d;
  assign sck_fall = ~sck_q[TOP] & sck_d;
  assign fs_s     = fs_q[TOP];
  assign rxd_s    = rxd_q[TOP];
endmodule

// File: rtl/sio_frame_timer.sv
module sio_frame_timer #(
  parameter int FRAME_LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_rise,
  input  logic fs_s,
  input  logic ctl_pending,
  output logic norm_sync,
  output logic sec_sync
);
  localparam int PW   = $clog2(FRAME_LEN) + 1;
  localparam int HALF = FRAME_LEN / 2;
  localparam logic [PW-1:0] SEC_POS = PW'(HALF - 1);
  localparam logic [PW-1:0] POS_MAX = {PW{1'b1}};

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= POS_MAX;
      norm_sync <= 1'b0;
      sec_sync  <= 1'b0;
    end else begin
      norm_sync <= 1'b0;
      sec_sync  <= 1'b0;
      if (sck_rise) begin
        if (fs_s && ctl_pending && pos == SEC_POS) begin
          sec_sync <= 1'b1;
          pos      <= pos + 1'b1;
        end else if (fs_s) begin
          norm_sync <= 1'b1;
          pos       <= '0;
        end else if (pos != POS_MAX) begin
          pos <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              norm_sync,
  input  logic              sec_sync,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              rxd_s,
  input  logic [SLOT_W-1:0] tx_audio,
  input  logic [SLOT_W-1:0] ctl_word,
  input  logic              ctl_pending,
  output logic              txd,
  output logic [SLOT_W-1:0] rx_word,
  output logic              rx_done,
  output slot_kind_e        rx_kind
);
  localparam int CW = $clog2(SLOT_W + 1);
  localparam logic [CW-1:0] FULL = CW'(SLOT_W);

  logic [SLOT_W-1:0] tx_sh, rx_sh;
  logic [CW-1:0]     tx_left, rx_left;
  slot_kind_e        kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      tx_left <= '0;
      rx_left <= '0;
      kind    <= SLOT_AUDIO;
      txd     <= 1'b0;
      rx_word <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (norm_sync) begin
        tx_sh   <= {tx_audio[SLOT_W-1:1], ctl_pending};
        tx_left <= FULL;
        rx_left <= FULL;
        kind    <= SLOT_AUDIO;
      end else if (sec_sync) begin
        tx_sh   <= ctl_word;
        tx_left <= FULL;
        rx_left <= FULL;
        kind    <= SLOT_CTRL;
      end else begin
        if (sck_fall) begin
          if (tx_left != '0) begin
            txd     <= tx_sh[SLOT_W-1];
            tx_sh   <= tx_sh << 1;
            tx_left <= tx_left - 1'b1;
          end else begin
            txd <= 1'b0;
          end
        end
        if (sck_rise && rx_left != '0) begin
          rx_sh   <= {rx_sh[SLOT_W-2:0], rxd_s};
          rx_left <= rx_left - 1'b1;
          if (rx_left == CW'(1)) begin
            rx_word <= {rx_sh[SLOT_W-2:0], rxd_s};
            rx_done <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_kind = kind;
endmodule

// File: rtl/sio_codec_slave.sv
module sio_codec_slave
  import sio_pkg::*;
#(
  parameter int FRAME_LEN   = 128,
  parameter int SLOT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_in,
  input  logic              fs_in,
  input  logic              rxd_in,
  output logic              txd_out,
  input  logic [SLOT_W-1:0] tx_audio,
  input  logic              ctl_wr,
  input  logic [SLOT_W-1:0] ctl_wdata,
  output logic              ctl_pending,
  output logic [SLOT_W-1:0] rx_audio,
  output logic              rx_audio_vld,
  output logic [SLOT_W-1:0] rx_ctl,
  output logic              rx_ctl_vld
);
  logic sck_rise, sck_fall, fs_s, rxd_s;
  logic norm_sync, sec_sync, rx_done;
  logic [SLOT_W-1:0] ctl_word, rx_word;
  slot_kind_e rx_kind;

  sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_in(sck_in), .fs_in(fs_in), .rxd_in(rxd_in),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .fs_s(fs_s), .rxd_s(rxd_s)
  );

  sio_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .fs_s(fs_s),
    .ctl_pending(ctl_pending), .norm_sync(norm_sync), .sec_sync(sec_sync)
  );

  sio_shifter #(.SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst(rst), .norm_sync(norm_sync), .sec_sync(sec_sync),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .rxd_s(rxd_s),
    .tx_audio(tx_audio), .ctl_word(ctl_word), .ctl_pending(ctl_pending),
    .txd(txd_out), .rx_word(rx_word), .rx_done(rx_done), .rx_kind(rx_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_word     <= '0;
      ctl_pending  <= 1'b0;
      rx_audio     <= '0;
      rx_audio_vld <= 1'b0;
      rx_ctl       <= '0;
      rx_ctl_vld   <= 1'b0;
    end else begin
      rx_audio_vld <= 1'b0;
      rx_ctl_vld   <= 1'b0;
      if (rx_done && rx_kind == SLOT_AUDIO) begin
        rx_audio     <= rx_word;
        rx_audio_vld <= 1'b1;
      end
      if (rx_done && rx_kind == SLOT_CTRL) begin
        rx_ctl      <= rx_word;
        rx_ctl_vld  <= 1'b1;
        ctl_pending <= 1'b0;
      end
      if (ctl_wr) begin
        ctl_word    <= ctl_wdata;
        ctl_pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_codec_slave_chk.sv
module sio_codec_slave_chk (
  input logic clk,
  input logic rst,
  input logic sck_fall,
  input logic ctl_wr,
  input logic ctl_pending,
  input logic txd_out,
  input logic rx_audio_vld,
  input logic rx_ctl_vld
);
  AST_AUDIO_VLD_ONE: assert property (@(posedge clk) disable iff (rst)
    rx_audio_vld |=> !rx_audio_vld); // R6
  AST_CTL_VLD_ONE: assert property (@(posedge clk) disable iff (rst)
    rx_ctl_vld |=> !rx_ctl_vld); // R5
  AST_CTL_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
    (rx_ctl_vld && !$past(ctl_wr)) |-> !ctl_pending); // R5
  AST_WR_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> ctl_pending); // R3
  AST_CTL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    rx_ctl_vld |-> $past(ctl_pending)); // R4
  AST_TXD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$past(sck_fall) |-> $stable(txd_out)); // R9
endmodule

bind sio_codec_slave sio_codec_slave_chk u_chk (
  .clk(clk), .rst(rst), .sck_fall(sck_fall), .ctl_wr(ctl_wr),
  .ctl_pending(ctl_pending), .txd_out(txd_out),
  .rx_audio_vld(rx_audio_vld), .rx_ctl_vld(rx_ctl_vld)
);

// File: tb/sio_codec_slave_tb.sv
module sio_codec_slave_tb;
  localparam int W = 16;
  localparam int NV = 6;
  // {req, sec, tx_audio, rx_audio word, ctl word, rx ctl word}
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'hA5A5, 16'h3C3C, 16'h0000, 16'h0000},
    {1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0000},
    {1'b1, 1'b1, 16'h1234, 16'hBEEF, 16'hC0DE, 16'h5AA5},
    {1'b1, 1'b0, 16'h8000, 16'h7FFF, 16'h0F0F, 16'h0000},
    {1'b0, 1'b1, 16'h4242, 16'h1111, 16'h0000, 16'h9669},
    {1'b0, 1'b0, 16'h0003, 16'h8001, 16'h0000, 16'h0000}
  };

  logic clk = 0, rst = 1;
  logic sck_in = 1, fs_in = 0, rxd_in = 0, ctl_wr = 0;
  logic [W-1:0] tx_audio = '0, ctl_wdata = '0;
  logic txd_out, ctl_pending, rx_audio_vld, rx_ctl_vld;
  logic [W-1:0] rx_audio, rx_ctl;
  int n_chk = 0, n_fail = 0, n_avld = 0, n_cvld = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sio_codec_slave u_dut (
    .clk(clk), .rst(rst), .sck_in(sck_in), .fs_in(fs_in), .rxd_in(rxd_in),
    .txd_out(txd_out), .tx_audio(tx_audio), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_pending(ctl_pending), .rx_audio(rx_audio), .rx_audio_vld(rx_audio_vld),
    .rx_ctl(rx_ctl), .rx_ctl_vld(rx_ctl_vld)
  );

  always @(posedge clk) begin
    if (rx_audio_vld) n_avld++;
    if (rx_ctl_vld) n_cvld++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [W-1:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  // one frame of 128 bit periods; sync at 0 and optionally at p
  task automatic do_frame(input int p, input logic [W-1:0] ra, input logic [W-1:0] rc,
                          output logic [W-1:0] ta, output logic [W-1:0] tc,
                          output logic stray);
    stray = 0; ta = '0; tc = '0;
    for (int k = 0; k < 128; k++) begin
      logic d, t;
      d = 0;
      if (k >= 1 && k <= W) d = ra[W-k];
      else if (p >= 0 && k > p && k <= p + W) d = rc[p+W-k];
      @(negedge clk); sck_in = 0; fs_in = (k == 0) || (k == p); rxd_in = d;
      repeat (6) @(negedge clk);
      t = txd_out;
      if (k >= 1 && k <= W) ta[W-k] = t;
      else if (p >= 0 && k > p && k <= p + W) tc[p+W-k] = t;
      else stray |= t;
      sck_in = 1;
      repeat (6) @(negedge clk);
    end
    fs_in = 0; rxd_in = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ta, tc, last_cw, rxc_before;
    logic stray, pend;
    int a0, c0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(txd_out == 0 && ctl_pending == 0, "R1", {txd_out, ctl_pending}, 0);
    check(rx_audio_vld == 0 && rx_ctl_vld == 0, "R1", {rx_audio_vld, rx_ctl_vld}, 0);
    check(rx_audio == 0 && rx_ctl == 0, "R1", rx_audio | rx_ctl, 0);

    pend = 0; last_cw = '0;
    for (int i = 0; i < NV; i++) begin
      logic req, sec;
      logic [W-1:0] txa, rxa, cw, rxc, exp_a;
      {req, sec, txa, rxa, cw, rxc} = VEC[i];
      if (req) begin write_ctl(cw); last_cw = cw; pend = 1; end
      tx_audio = txa;
      a0 = n_avld; c0 = n_cvld; rxc_before = rx_ctl;
      do_frame(sec ? 64 : -1, rxa, rxc, ta, tc, stray);
      exp_a = {txa[W-1:1], pend};
      check(ta == exp_a, pend ? "R3" : "R2", ta, exp_a);
      check(rx_audio == rxa && n_avld == a0 + 1, "R6", rx_audio, rxa);
      check(!stray, "R9", stray, 0);
      if (sec && pend) begin
        check(tc == last_cw, "R4", tc, last_cw);
        check(rx_ctl == rxc && n_cvld == c0 + 1, "R5", rx_ctl, rxc);
        pend = 0;
      end else begin
        check(rx_ctl == rxc_before && n_cvld == c0, "R5", rx_ctl, rxc_before);
      end
      check(ctl_pending == pend, "R5", ctl_pending, pend);
    end

    // R4: second write before the exchange replaces the word
    write_ctl(16'h1111);
    write_ctl(16'h2222);
    tx_audio = 16'h0F00;
    do_frame(64, 16'h0, 16'hABCD, ta, tc, stray);
    check(ta == 16'h0F01, "R3", ta, 16'h0F01);
    check(tc == 16'h2222, "R4", tc, 16'h2222);
    check(rx_ctl == 16'hABCD && !ctl_pending, "R5", rx_ctl, 16'hABCD);

    // R7: mid-frame sync with nothing pending restarts audio
    tx_audio = 16'h9999; a0 = n_avld; c0 = n_cvld; rxc_before = rx_ctl;
    do_frame(64, 16'h1357, 16'h2468, ta, tc, stray);
    check(tc == 16'h9998, "R7", tc, 16'h9998);
    check(rx_audio == 16'h2468 && n_avld == a0 + 2, "R7", rx_audio, 16'h2468);
    check(rx_ctl == rxc_before && n_cvld == c0, "R7", rx_ctl, rxc_before);

    // R8: stray sync at bit 40 realigns
    tx_audio = 16'h7777; a0 = n_avld;
    do_frame(40, 16'h0101, 16'hFEDC, ta, tc, stray);
    check(ta == 16'h7776 && tc == 16'h7776, "R8", tc, 16'h7776);
    check(rx_audio == 16'hFEDC && n_avld == a0 + 2, "R8", rx_audio, 16'hFEDC);
    check(!stray, "R9", stray, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule